// File: doc/BRIEF.md
# Direct-Mapped Branch Target Predictor

This block sits beside the decode stage of a five-stage in-order pipeline. It guesses the outcome and destination of control-transfer instructions early, so that a predicted-taken redirect can be issued before execute resolves the instruction. It keeps one table of 1024 slots, and the word-address bits of the program counter select a slot. Each slot holds a valid flag, an address tag, a destination address and a two-bit confidence counter.

The lookup side is combinational. A decode-stage PC goes in, and in the same cycle the block returns whether the table knows that PC, whether it predicts a redirect and where to. The update side is written on the clock edge. Execute reports the PC of a resolved branch or jump, whether control actually transferred, and the real destination. The block then creates or trains the slot. An unconditional jump is reported with the taken flag set, and it is stored and trained the same way as a taken branch.

Top module: `branch_target_predictor`

## Requirements
- R1: A synchronous active-high reset invalidates every slot, so any lookup after reset reports no hit, not taken, and a target of zero.
- R2: The slot index is PC[11:2] and the stored tag is PC[31:12]. PC[1:0] plays no part in lookup or update.
- R3: A lookup hits only when the selected slot is valid and its tag equals PC[31:12]. A different tag at the same index misses, and on a miss the reported target is zero and taken is 0.
- R4: A taken update (branch or jump) whose PC misses creates the slot with its tag, the given target and the counter at weakly-taken (2), so the next lookup of that PC hits and predicts taken.
- R5: A not-taken update whose PC misses leaves the table unchanged.
- R6: A taken update of a hit slot raises the counter by one and holds it at strongly-taken (3).
- R7: A not-taken update of a hit slot lowers the counter by one and holds it at strongly-not-taken (0). Taken is predicted exactly when the counter is 2 or 3 (its upper bit is 1).
- R8: Every update of a hit slot, taken or not, replaces the stored target with the reported one.
- R9: When a lookup and an update address the same slot in the same cycle, the lookup reports the contents from before that update.
- R10: A taken update that misses on a valid slot with a different tag replaces that slot, so the old PC then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_pc | input | 32 | PC being decoded |
| pred_hit | output | 1 | Table holds a valid slot for lk_pc |
| pred_taken | output | 1 | Predicted redirect |
| pred_target | output | 32 | Predicted destination, zero on a miss |
| upd_en | input | 1 | Resolved control transfer reported this cycle |
| upd_pc | input | 32 | PC of the resolved instruction |
| upd_taken | input | 1 | Control actually transferred (always 1 for jumps) |
| upd_target | input | 32 | Actual destination |

## Verification
The bench walks a counter to each end and pushes one step past it. A counter that wraps instead of saturating flips the next prediction, and the bench sees that flip. It updates a PC with a different tag at an occupied index. A design that ignores the tag would go on hitting the old PC, and one that refuses to replace the slot would miss the new one. It also offsets lookups by the two alignment bits and by one word, which catches an index taken from the wrong bit field. It runs a lookup and an update on the same slot in the same cycle and expects the pre-update target. A design that bypasses the write would show the new target one cycle early. Finally, a not-taken miss must leave no trace, and a second reset must wipe slots that were live.

// File: rtl/bp_pkg.sv
`timescale 1ns/1ps
package bp_pkg;
    localparam int PC_W    = 32;
    localparam int OFS_W   = 2;
    localparam int IDX_W   = 10;
    localparam int TAG_W   = PC_W - IDX_W - OFS_W;
    localparam int ENTRIES = 1 << IDX_W;

    typedef logic [PC_W-1:0]  pc_t;
    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [TAG_W-1:0] tag_t;

    typedef enum logic [1:0] {
        CTR_SNT = 2'd0,
        CTR_WNT = 2'd1,
        CTR_WT  = 2'd2,
        CTR_ST  = 2'd3
    } ctr_e;

    typedef struct packed {
        tag_t tag;
        pc_t  target;
        ctr_e ctr;
    } entry_t;

    function automatic ctr_e ctr_step(ctr_e cur, logic taken);
        logic [1:0] raw;
        if (taken) begin
            raw = (cur == CTR_ST) ? 2'd3 : cur + 2'd1;
        end else begin
            raw = (cur == CTR_SNT) ? 2'd0 : cur - 2'd1;
        end
        return ctr_e'(raw);
    endfunction

    function automatic logic ctr_says_taken(ctr_e cur);
        return cur[1];
    endfunction
endpackage

// File: rtl/bp_pc_split.sv
`timescale 1ns/1ps
module bp_pc_split
    import bp_pkg::*;
(
    input  pc_t  pc,
    output idx_t idx,
    output tag_t tag
);
    logic unused_align;

    assign idx          = pc[OFS_W +: IDX_W];
    assign tag          = pc[PC_W-1 -: TAG_W];
    assign unused_align = ^pc[OFS_W-1:0];
endmodule

// File: rtl/bp_table.sv
`timescale 1ns/1ps
module bp_table
    import bp_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  idx_t   rd_idx,
    output logic   rd_valid,
    output entry_t rd_entry,
    input  idx_t   up_idx,
    output logic   up_valid,
    output entry_t up_entry,
    input  logic   wr_en,
    input  idx_t   wr_idx,
    input  entry_t wr_entry
);
    logic [ENTRIES-1:0] valid_q;
    entry_t             mem_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_idx] <= wr_entry;
        end
    end

    // Reads see the array before this edge's write.
    assign rd_valid = valid_q[rd_idx];
    assign rd_entry = mem_q[rd_idx];
    assign up_valid = valid_q[up_idx];
    assign up_entry = mem_q[up_idx];

    // R4: a written slot is valid afterwards
    assert_write_sets_valid_R4: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> valid_q[$past(wr_idx)]);

    // R5: without a write no slot changes validity
    assert_no_write_keeps_valid_R5: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(valid_q));
endmodule

// File: rtl/bp_entry_update.sv
`timescale 1ns/1ps
module bp_entry_update
    import bp_pkg::*;
(
    input  logic   upd_en,
    input  logic   hit,
    input  logic   taken,
    input  tag_t   tag,
    input  pc_t    target,
    input  ctr_e   old_ctr,
    output logic   wr_en,
    output entry_t new_entry
);
    always_comb begin
        wr_en            = upd_en && (hit || taken);
        new_entry.tag    = tag;
        new_entry.target = target;
        new_entry.ctr    = hit ? ctr_step(old_ctr, taken) : CTR_WT;
    end
endmodule

// File: rtl/branch_target_predictor.sv
`timescale 1ns/1ps
module branch_target_predictor
    import bp_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] lk_pc,
    output logic            pred_hit,
    output logic            pred_taken,
    output logic [PC_W-1:0] pred_target,
    input  logic            upd_en,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic [PC_W-1:0] upd_target
);
    idx_t   lk_idx, upd_idx;
    tag_t   lk_tag, upd_tag;
    logic   rd_valid, up_valid, upd_hit, wr_en;
    entry_t rd_entry, up_entry, wr_entry;

    bp_pc_split u_lk_split (.pc(lk_pc),  .idx(lk_idx),  .tag(lk_tag));
    bp_pc_split u_up_split (.pc(upd_pc), .idx(upd_idx), .tag(upd_tag));

    bp_table u_table (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (lk_idx),
        .rd_valid (rd_valid),
        .rd_entry (rd_entry),
        .up_idx   (upd_idx),
        .up_valid (up_valid),
        .up_entry (up_entry),
        .wr_en    (wr_en),
        .wr_idx   (upd_idx),
        .wr_entry (wr_entry)
    );

    assign upd_hit = up_valid && (up_entry.tag == upd_tag);

    bp_entry_update u_upd (
        .upd_en    (upd_en),
        .hit       (upd_hit),
        .taken     (upd_taken),
        .tag       (upd_tag),
        .target    (upd_target),
        .old_ctr   (up_entry.ctr),
        .wr_en     (wr_en),
        .new_entry (wr_entry)
    );

    always_comb begin
        pred_hit    = rd_valid && (rd_entry.tag == lk_tag);
        pred_taken  = pred_hit && ctr_says_taken(rd_entry.ctr);
        pred_target = pred_hit ? rd_entry.target : '0;
    end

    // R3: no redirect without a hit
    assert_taken_needs_hit_R3: assert property (@(posedge clk) disable iff (rst)
        pred_taken |-> pred_hit);

    // R4: a taken miss allocates at weakly-taken
    assert_alloc_weak_R4: assert property (@(posedge clk) disable iff (rst)
        (upd_en && !upd_hit && upd_taken) |-> (wr_en && wr_entry.ctr == CTR_WT));

    // R5: a not-taken miss writes nothing
    assert_no_alloc_R5: assert property (@(posedge clk) disable iff (rst)
        (upd_en && !upd_hit && !upd_taken) |-> !wr_en);

    // R6: the counter holds at the top
    assert_sat_up_R6: assert property (@(posedge clk) disable iff (rst)
        (upd_en && upd_hit && upd_taken && up_entry.ctr == CTR_ST)
        |-> (wr_en && wr_entry.ctr == CTR_ST));

    // R7: the counter holds at the bottom
    assert_sat_down_R7: assert property (@(posedge clk) disable iff (rst)
        (upd_en && upd_hit && !upd_taken && up_entry.ctr == CTR_SNT)
        |-> (wr_en && wr_entry.ctr == CTR_SNT));

    // R8: a hit update stores the reported target
    assert_target_rewrite_R8: assert property (@(posedge clk) disable iff (rst)
        (upd_en && upd_hit) |-> (wr_en && wr_entry.target == upd_target));
endmodule

// File: tb/tb_branch_target_predictor.sv
`timescale 1ns/1ps
module tb_branch_target_predictor;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] lk_pc = '0;
    logic        pred_hit, pred_taken;
    logic [31:0] pred_target;
    logic        upd_en = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic [31:0] upd_target = '0;

    int checks = 0;
    int fails  = 0;

    localparam logic [31:0] P1 = 32'h0000_4010;
    localparam logic [31:0] P2 = 32'h0000_4020;
    localparam logic [31:0] P3 = 32'h0001_0100;
    localparam logic [31:0] P4 = 32'h0002_0200;
    localparam logic [31:0] P5 = 32'h0000_5010; // same index as P1, other tag

    always #5 clk = ~clk;

    branch_target_predictor dut (
        .clk(clk), .rst(rst), .lk_pc(lk_pc),
        .pred_hit(pred_hit), .pred_taken(pred_taken), .pred_target(pred_target),
        .upd_en(upd_en), .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_target(upd_target)
    );

    task automatic look(input string rq, input logic [31:0] pc,
                        input logic eh, input logic et, input logic [31:0] etg);
        @(negedge clk);
        lk_pc = pc;
        #1;
        checks++;
        if (pred_hit !== eh || pred_taken !== et || pred_target !== etg) begin
            fails++;
            $display("FAIL %s pc=%h actual hit=%b taken=%b tgt=%h expected hit=%b taken=%b tgt=%h",
                     rq, pc, pred_hit, pred_taken, pred_target, eh, et, etg);
        end
    endtask

    task automatic upd(input logic [31:0] pc, input logic tk, input logic [31:0] tg);
        @(negedge clk);
        upd_en = 1'b1; upd_pc = pc; upd_taken = tk; upd_target = tg;
        @(negedge clk);
        upd_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset_r1();
        look("R1", P1, 1'b0, 1'b0, 32'h0);
        look("R1", P3, 1'b0, 1'b0, 32'h0);
        look("R1", 32'hFFFF_FFFC, 1'b0, 1'b0, 32'h0);
    endtask

    task automatic t_alloc_r4();
        upd(P1, 1'b1, 32'h0000_5000); // jump or taken branch
        look("R4", P1, 1'b1, 1'b1, 32'h0000_5000);
    endtask

    task automatic t_no_alloc_r5();
        upd(P2, 1'b0, 32'h0000_9999);
        look("R5", P2, 1'b0, 1'b0, 32'h0);
    endtask

    task automatic t_fields_r2_r3();
        look("R2", P1 | 32'h3, 1'b1, 1'b1, 32'h0000_5000);
        look("R2", P1 + 32'h4, 1'b0, 1'b0, 32'h0);
        look("R3", P5, 1'b0, 1'b0, 32'h0);
    endtask

    task automatic t_sat_up_r6();
        upd(P3, 1'b1, 32'h0000_A000); // WT
        upd(P3, 1'b1, 32'h0000_A000); // ST
        upd(P3, 1'b1, 32'h0000_A000); // stays ST
        upd(P3, 1'b1, 32'h0000_A000); // stays ST
        upd(P3, 1'b0, 32'h0000_A000); // WT
        look("R6", P3, 1'b1, 1'b1, 32'h0000_A000);
        upd(P3, 1'b0, 32'h0000_A000); // WNT
        look("R6", P3, 1'b1, 1'b0, 32'h0000_A000);
    endtask

    task automatic t_sat_down_r7();
        upd(P4, 1'b1, 32'h0000_B000); // WT
        upd(P4, 1'b0, 32'h0000_B000); // WNT
        look("R7", P4, 1'b1, 1'b0, 32'h0000_B000);
        upd(P4, 1'b0, 32'h0000_B000); // SNT
        upd(P4, 1'b0, 32'h0000_B000); // stays SNT
        upd(P4, 1'b1, 32'h0000_B000); // WNT
        look("R7", P4, 1'b1, 1'b0, 32'h0000_B000);
        upd(P4, 1'b1, 32'h0000_B000); // WT
        look("R7", P4, 1'b1, 1'b1, 32'h0000_B000);
    endtask

    task automatic t_target_r8();
        upd(P1, 1'b1, 32'h0000_6000); // ST
        look("R8", P1, 1'b1, 1'b1, 32'h0000_6000);
        upd(P1, 1'b0, 32'h0000_7000); // WT, new target
        look("R8", P1, 1'b1, 1'b1, 32'h0000_7000);
    endtask

    task automatic t_replace_r10();
        upd(P5, 1'b1, 32'h0000_8000);
        look("R10", P5, 1'b1, 1'b1, 32'h0000_8000);
        look("R10", P1, 1'b0, 1'b0, 32'h0);
    endtask

    task automatic t_same_cycle_r9();
        @(negedge clk);
        lk_pc = P5;
        upd_en = 1'b1; upd_pc = P5; upd_taken = 1'b1; upd_target = 32'h0000_9000;
        #1;
        checks++;
        if (pred_hit !== 1'b1 || pred_target !== 32'h0000_8000) begin
            fails++;
            $display("FAIL R9 actual hit=%b tgt=%h expected hit=1 tgt=00008000",
                     pred_hit, pred_target);
        end
        @(negedge clk);
        upd_en = 1'b0;
        look("R9", P5, 1'b1, 1'b1, 32'h0000_9000);
    endtask

    task automatic t_rereset_r1();
        do_reset();
        look("R1", P5, 1'b0, 1'b0, 32'h0);
        look("R1", P3, 1'b0, 1'b0, 32'h0);
    endtask

    initial begin
        fork
            begin
                do_reset();
                t_reset_r1();
                t_alloc_r4();
                t_no_alloc_r5();
                t_fields_r2_r3();
                t_sat_up_r6();
                t_sat_down_r7();
                t_target_r8();
                t_replace_r10();
                t_same_cycle_r9();
                t_rereset_r1();
            end
            begin
                repeat (20000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog actual=running expected=finished");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule